// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt requests from 29 sources into a 32-bit cause register and gates them with a 32-bit enable mask. Each request, whether a level or a single-cycle pulse, sets its cause bit. The bit stays set until software clears it by writing to the cause register. Three cause positions hold no source. They are computed summaries over fixed groups of source bits, so software can test whole groups with a single read.

A plain register port reads and writes both registers. The block drives one interrupt line to the processor. It also presents the number of the lowest enabled pending source, so a dispatch routine can go straight to a handler without scanning the register. A write to the cause register clears only the bits written as 0. A clear-one-bit read-modify-write therefore cannot discard a request that lands in the same cycle.

Top module: `icm_ctrl`

## Requirements
- R1: After reset the cause register (select 0) and the mask register (select 1) both read zero, `cpu_irq` is 0 and `pend_none` is 1.
- R2: A request on `src_req[i]` (i in 1..29) sets cause bit i on the next clock edge. The bit stays set after the request is removed.
- R3: A write to the cause register (`reg_wr`=1, `reg_sel`=0) clears each source bit whose data bit is 0 and leaves unchanged each source bit whose data bit is 1. A write never sets a bit.
- R4: When a request and a clear-write hit the same cause bit in one cycle, the bit ends up set.
- R5: Writes to cause bit positions 0, 30 and 31 have no effect. Those positions always read their derived summary value.
- R6: A write to the mask register (`reg_sel`=1) stores data bits 29..1. Mask bits 0, 30 and 31 always read 0. A mask bit of 1 enables its source.
- R7: Cause bit 0 reads as the OR of source bits 29..1.
- R8: Cause bit 30 reads as the OR of source bits 29..26 and 20..1.
- R9: Cause bit 31 reads as the OR of source bits 25..1.
- R10: `pend_idx` is the lowest i in 1..29 with both cause bit i and mask bit i set, and `pend_none` is 0. When no such bit exists, `pend_none` is 1 and `pend_idx` is 0.
- R11: `cpu_irq` is a register. On each clock edge it takes the OR over bits 29..1 of (cause AND mask) as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 29 | Request lines, bit i drives cause bit i (indices 29..1) |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 1 | Register select: 0 cause, 1 mask (for both read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| cpu_irq | output | 1 | Registered interrupt line to the processor |
| pend_idx | output | 5 | Lowest enabled pending source number |
| pend_none | output | 1 | High when no enabled source is pending |

## Verification
The table patterns place single and multiple requests in each region the three summary groups split the source range into: below 21, the gap at 21..25, and 26..29. A wrong group boundary therefore changes at least one summary bit. The same patterns pair full, partial and empty masks with several requests, so that a lowest-index error or a mask that fails to gate a source shows up as a different `pend_idx` or `cpu_irq`. Directed cases then separate the clear-on-zero write from a set or toggle style write, a request racing a clear, writes to the derived positions, and a reset taken mid-operation.

// File: rtl/icm_pkg.sv
package icm_pkg;
  localparam int DW    = 32;
  localparam int NSRC  = 29;
  localparam int IDX_W = $clog2(NSRC + 1);
  localparam int PAD_W = DW - NSRC - 1;

  // Summary positions inside the cause word
  localparam int POS_ANY = 0;
  localparam int POS_MID = 30;
  localparam int POS_LOW = 31;

  localparam logic [DW-1:0] SRC_BITS = ((DW'(1) << NSRC) - DW'(1)) << 1;
  // Groups: 29..26 with 20..1, and 25..1
  localparam logic [DW-1:0] GRP_MID  = 32'h3C1F_FFFE;
  localparam logic [DW-1:0] GRP_LOW  = 32'h03FF_FFFE;

  localparam logic SEL_CAUSE = 1'b0;
  localparam logic SEL_MASK  = 1'b1;
endpackage

// File: rtl/icm_cause_bank.sv
module icm_cause_bank
  import icm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  output logic [DW-1:0] cause_q
);
  // Set has priority over clear: requests are never lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q & ~clr_vec) | set_vec;
  end

  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  p_req_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  p_keep_unwritten_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cause_q) & ~cause_q & ~$past(clr_vec)) == '0));

  p_no_write_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/icm_summary.sv
module icm_summary
  import icm_pkg::*;
(
  input  logic [DW-1:0] cause_q,
  output logic [DW-1:0] cause_view
);
  always_comb begin
    cause_view          = cause_q & SRC_BITS;
    cause_view[POS_ANY] = |(cause_q & SRC_BITS);
    cause_view[POS_MID] = |(cause_q & GRP_MID);
    cause_view[POS_LOW] = |(cause_q & GRP_LOW);
  end
endmodule

// File: rtl/icm_lowest.sv
module icm_lowest
  import icm_pkg::*;
(
  input  logic [NSRC:1]    hits,
  output logic [IDX_W-1:0] idx,
  output logic             none
);
  // Walk downward so the lowest set index is written last.
  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = NSRC; i >= 1; i--) begin
      if (hits[i]) begin
        idx  = IDX_W'(i);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/icm_ctrl.sv
module icm_ctrl
  import icm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC:1]    src_req,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             cpu_irq,
  output logic [IDX_W-1:0] pend_idx,
  output logic             pend_none
);
  logic [DW-1:0] set_vec, clr_vec, cause_q, cause_view, mask_q, hits;
  logic          wr_cause, wr_mask;

  assign wr_cause = reg_wr && (reg_sel == SEL_CAUSE);
  assign wr_mask  = reg_wr && (reg_sel == SEL_MASK);
  assign set_vec  = {{PAD_W{1'b0}}, src_req, 1'b0};
  // Summary positions are masked out: they are never stored.
  assign clr_vec  = wr_cause ? (~reg_wdata & SRC_BITS) : '0;

  icm_cause_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .cause_q (cause_q)
  );

  icm_summary u_sum (
    .cause_q    (cause_q),
    .cause_view (cause_view)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata & SRC_BITS;
  end

  assign hits = cause_q & mask_q;

  icm_lowest u_enc (
    .hits (hits[NSRC:1]),
    .idx  (pend_idx),
    .none (pend_none)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= |hits[NSRC:1];
  end

  assign reg_rdata = (reg_sel == SEL_MASK) ? mask_q : cause_view;

  p_summary_slots_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~SRC_BITS) == '0);

  p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata & SRC_BITS)));

  p_mid_implies_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_view[POS_MID] || cause_view[POS_LOW]) |-> cause_view[POS_ANY]);

  p_pend_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_none |-> (hits[pend_idx] && ((hits & ((DW'(1) << pend_idx) - DW'(1))) == '0)));

  p_pend_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_none |-> (hits == '0 && pend_idx == '0));

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(|hits)));
endmodule

// File: tb/icm_ctrl_bench.sv
module icm_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:1] src_req = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;
  logic [4:0]  pend_idx;
  logic        pend_none;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  icm_ctrl u_icm_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .pend_idx(pend_idx), .pend_none(pend_none)
  );

  // Stimulus: request pattern, mask. Expected: {b31,b30,b0}, index, none.
  localparam int NV = 8;
  localparam logic [31:0] V_REQ  [NV] = '{32'h0000_0020, 32'h0040_0000, 32'h0800_0000,
                                          32'h2000_0008, 32'h0120_0400, 32'h0020_0000,
                                          32'h0000_0000, 32'h0400_0000};
  localparam logic [31:0] V_MASK [NV] = '{32'h0000_0020, 32'h3FFF_FFFE, 32'h0000_0000,
                                          32'h2000_0000, 32'h3FFF_FFFE, 32'h0020_0000,
                                          32'h3FFF_FFFE, 32'h0400_0000};
  localparam logic [2:0]  V_SUM  [NV] = '{3'b111, 3'b101, 3'b011, 3'b111,
                                          3'b111, 3'b101, 3'b000, 3'b011};
  localparam logic [4:0]  V_IDX  [NV] = '{5'd5, 5'd22, 5'd0, 5'd29, 5'd10, 5'd21, 5'd0, 5'd26};
  localparam logic        V_NONE [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] r);
    @(negedge clk);
    src_req = r[29:1];
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic rd_cause(output logic [31:0] v);
    reg_sel = 1'b0; #1; v = reg_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd_cause(v); check("R1 cause", v, 32'h0);
    reg_sel = 1'b1; #1; check("R1 mask", reg_rdata, 32'h0);
    check("R1 irq", {31'b0, cpu_irq}, 32'h0);
    check("R1 none", {31'b0, pend_none}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      wr(1'b0, 32'h0);
      wr(1'b1, V_MASK[k]);
      pulse(V_REQ[k]);
      check("R11 latency", {31'b0, cpu_irq}, 32'h0);
      rd_cause(v);
      check("R2 latched", v & 32'h3FFF_FFFE, V_REQ[k]);
      check("R7 R8 R9 summary", {29'b0, v[31], v[30], v[0]}, {29'b0, V_SUM[k]});
      check("R10 idx", {27'b0, pend_idx}, {27'b0, V_IDX[k]});
      check("R10 none", {31'b0, pend_none}, {31'b0, V_NONE[k]});
      @(negedge clk);
      check("R11 irq", {31'b0, cpu_irq}, {31'b0, |(V_REQ[k] & V_MASK[k])});
    end

    // R3 clear-on-zero write
    wr(1'b0, 32'h0);
    pulse(32'h0000_0088);
    wr(1'b0, 32'hFFFF_FFF7);
    rd_cause(v); check("R3 clear one", v & 32'h3FFF_FFFE, 32'h0000_0080);

    // R4 request racing a clear
    @(negedge clk);
    src_req = 29'(32'h0000_0200 >> 1);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0;
    @(negedge clk);
    src_req = '0; reg_wr = 1'b0;
    rd_cause(v); check("R4 race", v & 32'h3FFF_FFFE, 32'h0000_0200);

    // R5 summary positions ignore writes
    wr(1'b0, 32'h3FFF_FFFE);
    rd_cause(v); check("R5 zero to summary", v, 32'hC000_0201);
    wr(1'b0, 32'h0);
    wr(1'b0, 32'hC000_0001);
    rd_cause(v); check("R5 ones to summary", v, 32'h0);

    // R6 mask storage
    wr(1'b1, 32'hFFFF_FFFF);
    reg_sel = 1'b1; #1; check("R6 mask", reg_rdata, 32'h3FFF_FFFE);

    // R1 reset mid-operation
    pulse(32'h0010_0000);
    @(negedge clk);
    check("R11 pre-reset irq", {31'b0, cpu_irq}, 32'h1);
    rst_n = 1'b0;
    #1;
    rd_cause(v); check("R1 cause after reset", v, 32'h0);
    reg_sel = 1'b1; #1; check("R1 mask after reset", reg_rdata, 32'h0);
    check("R1 irq after reset", {31'b0, cpu_irq}, 32'h0);
    check("R1 none after reset", {31'b0, pend_none}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule